// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This unit makes two decisions for a processor core's hardware interrupt path. It decides whether an interrupt should be requested, and it computes the offset of the handler entry point relative to the exception base. Three modes exist, chosen by two configuration bits.

- In legacy mode, each status bit masks one pending line, and the offset is one of two fixed values.
- In internal vectored mode, the same per-line masking applies. The unit then searches the pending lines itself, from line 0 upward, one line per clock, to find the vector.
- In external vectored mode, an outside interrupt controller places an encoded level on the pending field. The status field acts as a priority threshold, and the pending value is itself the vector.

The request flag is combinational. The handler offset is computed after a one-cycle take strobe and is written to a register. A one-cycle done pulse marks that the offset is valid. In both vectored modes the offset is the vector base 0x200 plus the vector times a programmable step, where the step is the spacing field multiplied by 32.

Top module: `irq_vector_unit`

## Requirements
- R1: With `ext_vec_i` low, `irq_req_o` is 1 exactly when `(pend_i & lvl_mask_i)` is non-zero.
- R2: With `ext_vec_i` high, `irq_req_o` is 1 exactly when `pend_i > lvl_mask_i` as unsigned numbers. This holds whatever `int_vec_i` is.
- R3: With both mode bits low, a take produces offset 0x180 when `vsel_i` is 0 and 0x200 when `vsel_i` is 1. The spacing field is ignored. `done_o` rises in the cycle right after the edge that samples `take_i`.
- R4: In either vectored mode, the offset is 0x200 + vector × (`spacing_i` × 32). A spacing of 0 gives 0x200 for every vector.
- R5: In internal vectored mode (`int_vec_i`=1, `ext_vec_i`=0), the vector is the index of the lowest set bit of `pend_i`. `pend_i` and `spacing_i` are captured at the sampling edge. When bit k is found, `done_o` rises k+1 clock edges after the sampling edge.
- R6: In internal vectored mode with no pending bit set, the vector is 8. `done_o` rises 8 edges after the sampling edge.
- R7: In external vectored mode, the vector is the raw 8-bit `pend_i` value. This holds even when `int_vec_i` is also 1. `done_o` rises in the cycle right after the sampling edge.
- R8: A take that arrives during a running search is ignored. `done_o` is a single-cycle pulse for each result. `offset_o` holds its value until the next result.
- R9: Synchronous active-high reset clears `offset_o` to 0, clears `done_o` and stops any search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | 8 | Pending field: line bits, or the encoded level in external mode |
| lvl_mask_i | input | 8 | Per-line mask, or the priority threshold in external mode |
| int_vec_i | input | 1 | Internal vectored mode enable |
| ext_vec_i | input | 1 | External vectored mode enable; takes precedence |
| vsel_i | input | 1 | Legacy offset select (0: 0x180, 1: 0x200) |
| spacing_i | input | 5 | Vector spacing in 32-byte steps |
| take_i | input | 1 | One-cycle take-interrupt strobe |
| irq_req_o | output | 1 | Interrupt request |
| offset_o | output | 19 | Registered handler offset |
| done_o | output | 1 | One-cycle pulse: offset_o is valid |

## Verification
The request flag is combinational, so it is checked one nanosecond after its inputs change. Each offset has a due cycle, counted from the edge that samples the take strobe:
- the same edge for legacy and external modes;
- k+1 edges later when internal search finds bit k;
- 8 edges later when internal search finds nothing.

The driver records the due cycle together with the expected offset. The monitor compares both on the falling edge where `done_o` is high. It also flags any pulse that is early, late or unexpected. The driver changes `pend_i` and `spacing_i` right after each take, which exercises the capture of those inputs.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  parameter int PEND_W    = 8;
  parameter int SPC_W     = 5;
  parameter int SPC_SHIFT = 5;
  parameter int OFF_W     = PEND_W + SPC_W + SPC_SHIFT + 1;
  parameter int BASE_LEGACY = 'h180;
  parameter int BASE_VEC    = 'h200;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_INTVEC = 2'd1,
    MODE_EXTVEC = 2'd2
  } irq_mode_e;

  // External mode wins when both enables are set.
  function automatic irq_mode_e f_mode(input logic int_en, input logic ext_en);
    if (ext_en)      return MODE_EXTVEC;
    else if (int_en) return MODE_INTVEC;
    else             return MODE_LEGACY;
  endfunction

  function automatic logic [OFF_W-1:0] f_legacy_offset(input logic vsel);
    return vsel ? OFF_W'(BASE_VEC) : OFF_W'(BASE_LEGACY);
  endfunction

  function automatic logic [OFF_W-1:0] f_vec_offset(input logic [PEND_W-1:0] vec,
                                                    input logic [SPC_W-1:0]  spc);
    logic [OFF_W-1:0] step;
    step = OFF_W'(spc) << SPC_SHIFT;
    return OFF_W'(BASE_VEC) + OFF_W'(vec) * step;
  endfunction
endpackage

// File: rtl/irq_request_eval.sv
module irq_request_eval
  import irq_vec_pkg::*;
(
  input  irq_mode_e         mode_i,
  input  logic [PEND_W-1:0] pend_i,
  input  logic [PEND_W-1:0] lvl_mask_i,
  output logic              req_o
);
  logic masked_hit;
  logic above_level;

  assign masked_hit  = |(pend_i & lvl_mask_i);
  assign above_level = (pend_i > lvl_mask_i);

  always_comb begin
    if (mode_i == MODE_EXTVEC) req_o = above_level;
    else                       req_o = masked_hit;
  end
endmodule

// File: rtl/irq_bit_scanner.sv
module irq_bit_scanner #(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [W-1:0]             pend_i,
  output logic                     busy_o,
  output logic                     finish_o,
  output logic [$clog2(W+1)-1:0]   vec_o
);
  localparam int SEL_W = $clog2(W);
  localparam int IDX_W = $clog2(W+1);

  logic             busy_q;
  logic [W-1:0]     shadow_q;
  logic [SEL_W-1:0] idx_q;
  logic             cur_bit;
  logic             last_bit;

  assign cur_bit  = shadow_q[idx_q];
  assign last_bit = (idx_q == SEL_W'(W-1));
  assign finish_o = busy_q & (cur_bit | last_bit);
  assign busy_o   = busy_q;
  assign vec_o    = cur_bit ? IDX_W'(idx_q) : IDX_W'(W);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      shadow_q <= '0;
      idx_q    <= '0;
    end else if (start_i && !busy_q) begin
      busy_q   <= 1'b1;
      shadow_q <= pend_i;
      idx_q    <= '0;
    end else if (busy_q) begin
      if (finish_o) busy_q <= 1'b0;
      else          idx_q  <= idx_q + 1'b1;
    end
  end

  // R5: one line per cycle until a hit
  assert_scan_advance_R5: assert property (@(posedge clk) disable iff (rst)
    busy_q && !finish_o |=> busy_q && idx_q == $past(idx_q) + 1'b1);

  // R5: a hit is the lowest set line of the captured field
  assert_scan_lowest_R5: assert property (@(posedge clk) disable iff (rst)
    finish_o && cur_bit |-> (shadow_q & ((W'(1) << idx_q) - W'(1))) == '0);

  // R6: ending without a hit means nothing was pending
  assert_scan_none_R6: assert property (@(posedge clk) disable iff (rst)
    finish_o && !cur_bit |-> shadow_q == '0);
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        pend_i,
  input  logic [7:0]        lvl_mask_i,
  input  logic              int_vec_i,
  input  logic              ext_vec_i,
  input  logic              vsel_i,
  input  logic [4:0]        spacing_i,
  input  logic              take_i,
  output logic              irq_req_o,
  output logic [18:0]       offset_o,
  output logic              done_o
);
  localparam int IDX_W = $clog2(PEND_W+1);

  irq_mode_e        mode;
  logic             scan_busy;
  logic             scan_finish;
  logic [IDX_W-1:0] scan_vec;
  logic             accept;
  logic             start_scan;
  logic             start_direct;
  logic [OFF_W-1:0] direct_off;
  logic [OFF_W-1:0] scan_off;
  logic [SPC_W-1:0] spc_q;
  logic [OFF_W-1:0] offset_q;
  logic             done_q;

  assign mode = f_mode(int_vec_i, ext_vec_i);

  irq_request_eval u_req (
    .mode_i     (mode),
    .pend_i     (pend_i),
    .lvl_mask_i (lvl_mask_i),
    .req_o      (irq_req_o)
  );

  assign accept       = take_i & ~scan_busy;
  assign start_scan   = accept & (mode == MODE_INTVEC);
  assign start_direct = accept & (mode != MODE_INTVEC);

  irq_bit_scanner #(.W(PEND_W)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_scan),
    .pend_i   (pend_i),
    .busy_o   (scan_busy),
    .finish_o (scan_finish),
    .vec_o    (scan_vec)
  );

  assign direct_off = (mode == MODE_EXTVEC) ? f_vec_offset(pend_i, spacing_i)
                                            : f_legacy_offset(vsel_i);
  assign scan_off   = f_vec_offset(PEND_W'(scan_vec), spc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q <= '0;
      done_q   <= 1'b0;
      spc_q    <= '0;
    end else begin
      done_q <= start_direct | scan_finish;
      if (start_direct)     offset_q <= direct_off;
      else if (scan_finish) offset_q <= scan_off;
      if (start_scan)       spc_q    <= spacing_i;
    end
  end

  assign offset_o = offset_q;
  assign done_o   = done_q;

  // R1: with per-line masking, no overlap means no request
  assert_mask_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !ext_vec_i && (pend_i & lvl_mask_i) == '0 |-> !irq_req_o);

  // R2: at or below threshold means no request
  assert_level_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ext_vec_i && pend_i <= lvl_mask_i |-> !irq_req_o);

  // R3 / R7: single-cycle modes finish on the sampling edge
  assert_direct_done_R3: assert property (@(posedge clk) disable iff (rst)
    start_direct |=> done_o && offset_o == $past(direct_off));

  // R4: zero spacing collapses every vector onto the base
  assert_zero_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    scan_finish && spc_q == '0 |=> offset_o == OFF_W'(BASE_VEC));

  // R4: every offset is a multiple of 32
  assert_offset_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    offset_o[SPC_SHIFT-1:0] == '0);

  // R8: no result means a held offset and no pulse
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(start_direct || scan_finish) |=> $stable(offset_o) && !done_o);
endmodule

// File: tb/irq_vector_unit_bench.sv
`timescale 1ns/1ps
module irq_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pend_i = '0;
  logic [7:0]  lvl_mask_i = '0;
  logic        int_vec_i = 1'b0;
  logic        ext_vec_i = 1'b0;
  logic        vsel_i = 1'b0;
  logic [4:0]  spacing_i = '0;
  logic        take_i = 1'b0;
  logic        irq_req_o;
  logic [18:0] offset_o;
  logic        done_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;

  int    due_q[$];
  int    off_q[$];
  string tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_vector_unit u_irq_vector_unit (
    .clk(clk), .rst(rst), .pend_i(pend_i), .lvl_mask_i(lvl_mask_i),
    .int_vec_i(int_vec_i), .ext_vec_i(ext_vec_i), .vsel_i(vsel_i),
    .spacing_i(spacing_i), .take_i(take_i), .irq_req_o(irq_req_o),
    .offset_o(offset_o), .done_o(done_o)
  );

  function automatic int model_vec(input logic [7:0] p, input logic vi, input logic ve);
    int v;
    if (ve) return int'(p);
    v = 8;
    for (int i = 7; i >= 0; i--) if (p[i]) v = i;
    return v;
  endfunction

  function automatic int model_off(input logic [7:0] p, input logic vi, input logic ve,
                                   input logic vs, input logic [4:0] sp);
    if (!vi && !ve) return vs ? 512 : 384;
    return 512 + model_vec(p, vi, ve) * int'(sp) * 32;
  endfunction

  function automatic int model_lat(input logic [7:0] p, input logic vi, input logic ve);
    int v;
    if (ve || !vi) return 0;
    v = model_vec(p, vi, ve);
    return (v < 8) ? v + 1 : 8;
  endfunction

  function automatic logic model_req(input logic [7:0] p, input logic [7:0] m, input logic ve);
    if (ve) return (p > m);
    return (p & m) != 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic req_case(input logic [7:0] p, input logic [7:0] m, input logic vi,
                          input logic ve, input string tag);
    @(negedge clk);
    pend_i = p; lvl_mask_i = m; int_vec_i = vi; ext_vec_i = ve;
    #1;
    check(tag, int'(irq_req_o), int'(model_req(p, m, ve)));
  endtask

  task automatic take_case(input logic [7:0] p, input logic vi, input logic ve,
                           input logic vs, input logic [4:0] sp, input string tag);
    @(negedge clk);
    pend_i = p; int_vec_i = vi; ext_vec_i = ve; vsel_i = vs; spacing_i = sp;
    take_i = 1'b1;
    due_q.push_back(cyc + 1 + model_lat(p, vi, ve));
    off_q.push_back(model_off(p, vi, ve, vs, sp));
    tag_q.push_back(tag);
    @(negedge clk);
    take_i = 1'b0;
    pend_i = ~p;          // later input changes must not affect the result
    spacing_i = ~sp;
    while (due_q.size() != 0) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        if (due_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R8 unexpected done actual=1 expected=0 offset=%0d", offset_o);
        end else begin
          int ed, eo; string t;
          ed = due_q.pop_front(); eo = off_q.pop_front(); t = tag_q.pop_front();
          check({t, " offset"}, int'(offset_o), eo);
          check({t, " due cycle"}, cyc, ed);
        end
      end else if (due_q.size() != 0 && cyc > due_q[0]) begin
        int ed, eo; string t;
        ed = due_q.pop_front(); eo = off_q.pop_front(); t = tag_q.pop_front();
        n_checks++; n_fail++;
        $display("FAIL %s done missing actual_cycle=%0d expected_cycle=%0d", t, cyc, ed);
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements) actual_cycle=%0d expected below 30000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    #1;
    check("R9 offset after reset", int'(offset_o), 0);
    check("R9 done after reset", int'(done_o), 0);

    // R1: per-line masking
    req_case(8'h14, 8'h04, 1'b0, 1'b0, "R1 overlap legacy");
    req_case(8'h14, 8'h0A, 1'b0, 1'b0, "R1 no overlap legacy");
    req_case(8'h81, 8'h80, 1'b1, 1'b0, "R1 overlap internal");
    req_case(8'h81, 8'h7E, 1'b1, 1'b0, "R1 no overlap internal");
    // R2: threshold compare, unsigned, precedence
    req_case(8'd5, 8'd5, 1'b0, 1'b1, "R2 equal level");
    req_case(8'd6, 8'd5, 1'b0, 1'b1, "R2 above level");
    req_case(8'h80, 8'h7F, 1'b0, 1'b1, "R2 unsigned compare");
    req_case(8'd2, 8'd1, 1'b1, 1'b1, "R2 both enables");
    req_case(8'd3, 8'd3, 1'b1, 1'b1, "R2 both enables equal");

    // R3: legacy offsets
    take_case(8'h01, 1'b0, 1'b0, 1'b0, 5'd7, "R3 vsel0");
    take_case(8'h01, 1'b0, 1'b0, 1'b1, 5'd7, "R3 vsel1");
    // R5: internal search
    take_case(8'h01, 1'b1, 1'b0, 1'b0, 5'd1, "R5 bit0");
    take_case(8'h28, 1'b1, 1'b0, 1'b0, 5'd3, "R5 bit3");
    take_case(8'h80, 1'b1, 1'b0, 1'b0, 5'd31, "R5 bit7");
    take_case(8'h40, 1'b1, 1'b0, 1'b0, 5'd2, "R5 snapshot bit6");
    // R6: nothing pending
    take_case(8'h00, 1'b1, 1'b0, 1'b0, 5'd2, "R6 empty");
    // R7: external vector
    take_case(8'hFF, 1'b0, 1'b1, 1'b0, 5'd31, "R7 max vector");
    take_case(8'h28, 1'b1, 1'b1, 1'b0, 5'd1, "R7 both enables");
    // R4: zero spacing
    take_case(8'h10, 1'b1, 1'b0, 1'b0, 5'd0, "R4 zero spacing internal");
    take_case(8'h09, 1'b0, 1'b1, 1'b0, 5'd0, "R4 zero spacing external");

    // R8: take during search is ignored, offset held after the result
    @(negedge clk);
    pend_i = 8'h00; int_vec_i = 1'b1; ext_vec_i = 1'b0; spacing_i = 5'd1; take_i = 1'b1;
    due_q.push_back(cyc + 1 + 8);
    off_q.push_back(512 + 8 * 32);
    tag_q.push_back("R8 search with ignored take");
    @(negedge clk); take_i = 1'b0;
    @(negedge clk);
    ext_vec_i = 1'b1; pend_i = 8'h03; take_i = 1'b1;
    @(negedge clk); take_i = 1'b0;
    while (due_q.size() != 0) @(negedge clk);
    held = int'(offset_o);
    repeat (3) @(negedge clk);
    check("R8 offset held", int'(offset_o), held);
    check("R8 done single pulse", int'(done_o), 0);

    // R9: reset during a search
    @(negedge clk);
    pend_i = 8'h80; int_vec_i = 1'b1; ext_vec_i = 1'b0; take_i = 1'b1;
    @(negedge clk); take_i = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 offset cleared", int'(offset_o), 0);
    repeat (10) @(negedge clk);
    check("R9 search stopped", int'(done_o), 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule